// File: doc/BRIEF.md
# Extended-Operand Add/Subtract Unit with Condition Flags

This block performs one integer add or subtract per accepted request. The second operand comes from a source register value that is first narrowed to a selected source width (byte, halfword, word or doubleword), widened back by zero or sign fill, then shifted left by a small amount. The operation runs at either 32-bit or 64-bit data size. When a flag update is requested, four condition flags (negative, zero, carry, overflow) are produced alongside the result.

The fill length is clipped to the data size minus the shift amount. Because of this, the redundant option codes give the same answer. On 32-bit operations, the word and doubleword codes behave the same whatever their signedness. On 64-bit operations, both doubleword codes are a pure shift. All outputs are registered, so a request presented on one clock edge appears on the outputs after that edge.

Top module: `ext_addsub_unit`

## Requirements
- R1: The option field is decoded as follows. Bits [1:0] give the source width: 00 = 8 bits, 01 = 16 bits, 10 = 32 bits, 11 = 64 bits. Bit [2] selects the fill: 0 = zero fill, 1 = sign fill from the top bit of the source width.
- R2: The filled operand is shifted left by `shamt` (0 to 4), and bits above the data size are discarded.
- R3: When `wide_sel` is 0, only bits [31:0] of both operands are used, and `out_result[63:32]` is zero.
- R4: When `wide_sel` is 0, option codes 010, 011, 110 and 111 give the same result and flags. That result is `a[31:0] ± (b[31:0] << shamt)` modulo 2^32.
- R5: When `wide_sel` is 1, option codes 011 and 111 both leave `b` unchanged before the shift.
- R6: Subtraction computes `a + ~op + 1`. The C flag is the carry out of the top bit at the data size, so C = 1 on a subtract means no borrow occurred.
- R7: The flags are packed as `out_flags` = {N,Z,C,V} in bits [3:0]. N is the top bit of the result at the data size. Z is 1 when the result at the data size is zero. V is 1 on signed overflow at the data size.
- R8: A `shamt` of 5, 6 or 7 with `in_valid` gives `out_illegal` = 1 and `out_result` = 0, and leaves `out_flags` unchanged.
- R9: `out_flags` changes only after a cycle with `in_valid`, `set_flags` and a legal shift all true. Otherwise it holds its value.
- R10: `out_valid` follows `in_valid` with one cycle of latency. A synchronous active-high `rst` clears `out_valid`, `out_flags`, `out_illegal` and `out_result`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| wide_sel | input | 1 | 1 = 64-bit operation, 0 = 32-bit operation |
| src_a | input | 64 | First operand |
| src_b | input | 64 | Source register value for the second operand |
| ext_opt | input | 3 | Fill option: {signed, width[1:0]} |
| shamt | input | 3 | Left shift applied after fill |
| do_sub | input | 1 | 1 = subtract, 0 = add |
| set_flags | input | 1 | Request a flag update |
| out_valid | output | 1 | Result valid |
| out_result | output | 64 | Result, upper half zero in 32-bit mode |
| out_flags | output | 4 | {N,Z,C,V} |
| out_illegal | output | 1 | Shift amount out of range |

## Verification
The flag update and the illegal-shift rejection can fall in the same cycle. This happens when a request with a shift of 5 to 7 arrives with `set_flags` high, directly after a legal flag-setting request. The bench first loads a known flag pattern, then sends back-to-back illegal requests. It then expects `out_illegal` high, a zero result, and the earlier flags kept exactly. A second case pairs a valid request with `set_flags` low. In that case the result must advance while the flags stay frozen.

// File: rtl/xaddsub_pkg.sv
package xaddsub_pkg;

    typedef enum logic [1:0] {
        EW_BYTE  = 2'b00,
        EW_HALF  = 2'b01,
        EW_WORD  = 2'b10,
        EW_DWORD = 2'b11
    } ext_width_e;

    typedef struct packed {
        logic       fill_signed;
        ext_width_e width;
    } ext_opt_t;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } nzcv_t;

    // Number of source bits kept by a width code; doubleword keeps all of them.
    function automatic int unsigned src_bits(ext_width_e w, int unsigned full_w);
        case (w)
            EW_BYTE: return 8;
            EW_HALF: return 16;
            EW_WORD: return 32;
            default: return full_w;
        endcase
    endfunction

    // Fill length is clipped so that nothing past the data size survives the shift.
    function automatic int unsigned clip_len(int unsigned src, int unsigned dsize,
                                             int unsigned sh);
        int unsigned room;
        room = (sh < dsize) ? (dsize - sh) : 1;
        return (src < room) ? src : room;
    endfunction

endpackage

// File: rtl/ext_operand_gen.sv
module ext_operand_gen
    import xaddsub_pkg::*;
#(
    parameter int unsigned DATA_W = 64,
    parameter int unsigned SH_W   = 3
) (
    input  logic [DATA_W-1:0] src_b,
    input  ext_opt_t          opt,
    input  logic [SH_W-1:0]   shamt,
    input  logic              wide_sel,
    output logic [DATA_W-1:0] op_out
);
    localparam int unsigned HALF_W = DATA_W / 2;

    int unsigned        dsize;
    int unsigned        keep;
    logic               fill_bit;
    logic [DATA_W-1:0]  filled;
    logic [DATA_W-1:0]  shifted;

    always_comb begin
        dsize    = wide_sel ? DATA_W : HALF_W;
        keep     = clip_len(src_bits(opt.width, DATA_W), dsize, int'(shamt));
        fill_bit = opt.fill_signed & src_b[keep-1];
        for (int i = 0; i < DATA_W; i++) begin
            filled[i] = (i < keep) ? src_b[i] : fill_bit;
        end
        shifted = filled << shamt;
        if (!wide_sel) begin
            shifted[DATA_W-1:HALF_W] = '0;
        end
        op_out = shifted;
    end

endmodule

// File: rtl/addsub_core.sv
module addsub_core
    import xaddsub_pkg::*;
#(
    parameter int unsigned DATA_W = 64
) (
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] op_in,
    input  logic              do_sub,
    input  logic              wide_sel,
    output logic [DATA_W-1:0] sum_out,
    output nzcv_t             flags_out
);
    localparam int unsigned HALF_W = DATA_W / 2;

    logic [DATA_W-1:0] lane_sum [2];
    nzcv_t             lane_flg [2];

    // Lane 0 works at half width, lane 1 at full width.
    for (genvar g = 0; g < 2; g++) begin : g_lane
        localparam int unsigned W = (g == 0) ? HALF_W : DATA_W;
        logic [W-1:0] a_w;
        logic [W-1:0] b_w;
        logic [W:0]   s_w;

        always_comb begin
            a_w = src_a[W-1:0];
            b_w = do_sub ? ~op_in[W-1:0] : op_in[W-1:0];
            s_w = {1'b0, a_w} + {1'b0, b_w} + {{W{1'b0}}, do_sub};
            lane_sum[g]   = '0;
            lane_sum[g][W-1:0] = s_w[W-1:0];
            lane_flg[g].n = s_w[W-1];
            lane_flg[g].z = (s_w[W-1:0] == '0);
            lane_flg[g].c = s_w[W];
            lane_flg[g].v = (a_w[W-1] == b_w[W-1]) && (s_w[W-1] != a_w[W-1]);
        end
    end

    assign sum_out   = wide_sel ? lane_sum[1] : lane_sum[0];
    assign flags_out = wide_sel ? lane_flg[1] : lane_flg[0];

endmodule

// File: rtl/result_stage.sv
module result_stage
    import xaddsub_pkg::*;
#(
    parameter int unsigned DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              bad_shift,
    input  logic              set_flags,
    input  logic [DATA_W-1:0] sum_in,
    input  nzcv_t             flags_in,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_result,
    output nzcv_t             out_flags,
    output logic              out_illegal
);
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            out_illegal <= 1'b0;
            out_result  <= '0;
            out_flags   <= '0;
        end else begin
            out_valid   <= in_valid;
            out_illegal <= in_valid & bad_shift;
            if (in_valid) begin
                out_result <= bad_shift ? '0 : sum_in;
            end
            if (in_valid && set_flags && !bad_shift) begin
                out_flags <= flags_in;
            end
        end
    end

endmodule

// File: rtl/ext_addsub_unit.sv
module ext_addsub_unit
    import xaddsub_pkg::*;
#(
    parameter int unsigned DATA_W    = 64,
    parameter int unsigned SH_W      = 3,
    parameter int unsigned MAX_SHIFT = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              wide_sel,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    input  logic [2:0]        ext_opt,
    input  logic [SH_W-1:0]   shamt,
    input  logic              do_sub,
    input  logic              set_flags,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_result,
    output logic [3:0]        out_flags,
    output logic              out_illegal
);
    localparam logic [SH_W-1:0] SH_LIMIT = SH_W'(MAX_SHIFT);

    ext_opt_t          opt_s;
    logic [DATA_W-1:0] op_val;
    logic [DATA_W-1:0] sum_val;
    nzcv_t             flg_val;
    nzcv_t             flg_q;
    logic              bad_shift;

    assign opt_s     = ext_opt_t'(ext_opt);
    assign bad_shift = (shamt > SH_LIMIT);

    ext_operand_gen #(.DATA_W(DATA_W), .SH_W(SH_W)) u_ext (
        .src_b    (src_b),
        .opt      (opt_s),
        .shamt    (shamt),
        .wide_sel (wide_sel),
        .op_out   (op_val)
    );

    addsub_core #(.DATA_W(DATA_W)) u_core (
        .src_a     (src_a),
        .op_in     (op_val),
        .do_sub    (do_sub),
        .wide_sel  (wide_sel),
        .sum_out   (sum_val),
        .flags_out (flg_val)
    );

    result_stage #(.DATA_W(DATA_W)) u_stage (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .bad_shift   (bad_shift),
        .set_flags   (set_flags),
        .sum_in      (sum_val),
        .flags_in    (flg_val),
        .out_valid   (out_valid),
        .out_result  (out_result),
        .out_flags   (flg_q),
        .out_illegal (out_illegal)
    );

    assign out_flags = flg_q;

endmodule

// File: rtl/ext_addsub_chk.sv
module ext_addsub_chk #(
    parameter int unsigned DATA_W    = 64,
    parameter int unsigned SH_W      = 3,
    parameter int unsigned MAX_SHIFT = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              wide_sel,
    input logic [SH_W-1:0]   shamt,
    input logic              set_flags,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_result,
    input logic [3:0]        out_flags,
    input logic              out_illegal
);
    localparam int unsigned HALF_W = DATA_W / 2;
    localparam logic [SH_W-1:0] SH_LIMIT = SH_W'(MAX_SHIFT);

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R10
    AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid); // R10
    AST_ILLEGAL_HOLDS_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (in_valid && shamt > SH_LIMIT) |=> (out_illegal && $stable(out_flags) && out_result == '0)); // R8
    AST_ILLEGAL_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
        out_illegal |-> out_valid); // R8
    AST_NOSET_HOLDS_FLAGS: assert property (@(posedge clk) disable iff (rst)
        !(in_valid && set_flags) |=> $stable(out_flags)); // R9
    AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !wide_sel) |=> (out_result[DATA_W-1:HALF_W] == '0)); // R3
    AST_ZERO_FLAG_MATCH: assert property (@(posedge clk) disable iff (rst)
        (in_valid && set_flags && shamt <= SH_LIMIT) |=>
        (out_flags[2] == ($past(wide_sel) ? (out_result == '0)
                                          : (out_result[HALF_W-1:0] == '0)))); // R7

endmodule

bind ext_addsub_unit ext_addsub_chk #(.DATA_W(DATA_W), .SH_W(SH_W), .MAX_SHIFT(MAX_SHIFT)) u_chk (.*);

// File: tb/sim_ext_addsub_unit.sv
`timescale 1ns/1ps
module sim_ext_addsub_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic        wide_sel;
    logic [63:0] src_a;
    logic [63:0] src_b;
    logic [2:0]  ext_opt;
    logic [2:0]  shamt;
    logic        do_sub;
    logic        set_flags;
    logic        out_valid;
    logic [63:0] out_result;
    logic [3:0]  out_flags;
    logic        out_illegal;

    int total = 0;
    int bad   = 0;
    logic [3:0] exp_flags;

    always #4 clk = ~clk;

    ext_addsub_unit u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .wide_sel(wide_sel),
        .src_a(src_a), .src_b(src_b), .ext_opt(ext_opt), .shamt(shamt),
        .do_sub(do_sub), .set_flags(set_flags), .out_valid(out_valid),
        .out_result(out_result), .out_flags(out_flags), .out_illegal(out_illegal)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference operand: fill to 64 bits from the chosen width, shift, trim.
    function automatic logic [63:0] ref_operand(logic wide, logic [63:0] b,
                                                logic [2:0] opt, logic [2:0] sh);
        logic [63:0] e;
        case (opt[1:0])
            2'b00: e = opt[2] ? {{56{b[7]}},  b[7:0]}  : {56'd0, b[7:0]};
            2'b01: e = opt[2] ? {{48{b[15]}}, b[15:0]} : {48'd0, b[15:0]};
            2'b10: e = opt[2] ? {{32{b[31]}}, b[31:0]} : {32'd0, b[31:0]};
            default: e = b;
        endcase
        e = e << sh;
        if (!wide) e[63:32] = 32'd0;
        return e;
    endfunction

    task automatic ref_calc(input logic wide, input logic [63:0] a, input logic [63:0] op,
                            input logic sub, output logic [63:0] r, output logic [3:0] f);
        logic [64:0]        s64;
        logic [32:0]        s32;
        logic signed [65:0] w64;
        logic signed [33:0] w32;
        logic               n, z, c, v;
        if (wide) begin
            s64 = sub ? ({1'b0, a} - {1'b0, op} + 65'h1_0000_0000_0000_0000)
                      : ({1'b0, a} + {1'b0, op});
            r = s64[63:0];
            c = s64[64];
            w64 = sub ? ($signed({{2{a[63]}}, a}) - $signed({{2{op[63]}}, op}))
                      : ($signed({{2{a[63]}}, a}) + $signed({{2{op[63]}}, op}));
            v = (w64 != $signed({{2{r[63]}}, r}));
            n = r[63];
            z = (r == 64'd0);
        end else begin
            s32 = sub ? ({1'b0, a[31:0]} - {1'b0, op[31:0]} + 33'h1_0000_0000)
                      : ({1'b0, a[31:0]} + {1'b0, op[31:0]});
            r = {32'd0, s32[31:0]};
            c = s32[32];
            w32 = sub ? ($signed({{2{a[31]}}, a[31:0]}) - $signed({{2{op[31]}}, op[31:0]}))
                      : ($signed({{2{a[31]}}, a[31:0]}) + $signed({{2{op[31]}}, op[31:0]}));
            v = (w32 != $signed({{2{r[31]}}, r[31:0]}));
            n = r[31];
            z = (r[31:0] == 32'd0);
        end
        f = {n, z, c, v};
    endtask

    // One request; outputs sampled on the negedge after the capturing posedge.
    task automatic run_op(input logic wide, input logic [63:0] a, input logic [63:0] b,
                          input logic [2:0] opt, input logic [2:0] sh, input logic sub,
                          input logic sf, output logic [63:0] r_act, output logic [3:0] f_act,
                          output logic v_act, output logic ill_act);
        @(negedge clk);
        in_valid = 1'b1; wide_sel = wide; src_a = a; src_b = b;
        ext_opt = opt; shamt = sh; do_sub = sub; set_flags = sf;
        @(negedge clk);
        in_valid = 1'b0; set_flags = 1'b0;
        r_act = out_result; f_act = out_flags; v_act = out_valid; ill_act = out_illegal;
    endtask

    // Runs a legal request and checks result, flags and valid against the model.
    task automatic op_and_check(input string req, input logic wide, input logic [63:0] a,
                                input logic [63:0] b, input logic [2:0] opt,
                                input logic [2:0] sh, input logic sub, input logic sf);
        logic [63:0] r, er, op;
        logic [3:0]  f, ef;
        logic        v, il;
        op = ref_operand(wide, b, opt, sh);
        ref_calc(wide, a, op, sub, er, ef);
        if (sf) exp_flags = ef;
        run_op(wide, a, b, opt, sh, sub, sf, r, f, v, il);
        check(r == er, req, r, er);
        check(f == exp_flags, req, {60'd0, f}, {60'd0, exp_flags});
        check(v && !il, "R10", {62'd0, v, il}, 64'd2);
    endtask

    task automatic t_reset;
        check(out_valid == 1'b0, "R10", {63'd0, out_valid}, 64'd0);
        check(out_flags == 4'd0, "R10", {60'd0, out_flags}, 64'd0);
        check(out_illegal == 1'b0, "R10", {63'd0, out_illegal}, 64'd0);
        check(out_result == 64'd0, "R10", out_result, 64'd0);
    endtask

    task automatic t_fill_modes;
        for (int o = 0; o < 8; o++) begin
            op_and_check("R1", 1'b1, 64'd0, 64'hF0E1_D2C3_B4A5_9687, 3'(o), 3'd0, 1'b0, 1'b1);
        end
        op_and_check("R1", 1'b1, 64'd0, 64'h0000_0000_0000_0087, 3'b100, 3'd0, 1'b0, 1'b0);
        check(out_result == 64'hFFFF_FFFF_FFFF_FF87, "R1", out_result, 64'hFFFF_FFFF_FFFF_FF87);
    endtask

    task automatic t_shift;
        for (int s = 0; s < 5; s++) begin
            op_and_check("R2", 1'b1, 64'h10, 64'hF000_0000_0000_0001, 3'b011, 3'(s), 1'b0, 1'b1);
        end
        op_and_check("R2", 1'b1, 64'd0, 64'h0000_0000_0000_00FF, 3'b000, 3'd4, 1'b0, 1'b0);
        check(out_result == 64'hFF0, "R2", out_result, 64'hFF0);
    endtask

    task automatic t_narrow_codes;
        logic [63:0] r, first_r;
        logic [3:0]  f, first_f;
        logic        v, il;
        logic [63:0] a, b, exp;
        a = 64'hFFFF_FFFF_8000_0010;
        b = 64'h1234_5678_8765_4321;
        for (int s = 0; s < 5; s++) begin
            exp = {32'd0, 32'(a[31:0] + (b[31:0] << s))};
            for (int k = 0; k < 4; k++) begin
                logic [2:0] code;
                code = (k == 0) ? 3'b010 : (k == 1) ? 3'b011 : (k == 2) ? 3'b110 : 3'b111;
                run_op(1'b0, a, b, code, 3'(s), 1'b0, 1'b1, r, f, v, il);
                if (k == 0) begin first_r = r; first_f = f; end
                check(r == exp, "R4", r, exp);
                check(f == first_f && r == first_r, "R4", {60'd0, f}, {60'd0, first_f});
                check(r[63:32] == 32'd0, "R3", r, exp);
            end
            exp_flags = first_f;
        end
        op_and_check("R4", 1'b0, a, b, 3'b111, 3'd3, 1'b1, 1'b1);
    endtask

    task automatic t_wide_dword;
        logic [63:0] r0, r1;
        logic [3:0]  f;
        logic        v, il;
        logic [63:0] b;
        b = 64'h8123_4567_89AB_CDEF;
        run_op(1'b1, 64'd0, b, 3'b011, 3'd2, 1'b0, 1'b0, r0, f, v, il);
        run_op(1'b1, 64'd0, b, 3'b111, 3'd2, 1'b0, 1'b0, r1, f, v, il);
        check(r0 == (b << 2), "R5", r0, b << 2);
        check(r1 == (b << 2), "R5", r1, b << 2);
    endtask

    task automatic t_flags;
        op_and_check("R7", 1'b1, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 3'b011, 3'd0, 1'b0, 1'b1);
        check(out_flags == 4'b1001, "R7", {60'd0, out_flags}, 64'b1001);
        op_and_check("R6", 1'b1, 64'd5, 64'd5, 3'b011, 3'd0, 1'b1, 1'b1);
        check(out_flags == 4'b0110, "R6", {60'd0, out_flags}, 64'b0110);
        op_and_check("R6", 1'b0, 64'd0, 64'd1, 3'b010, 3'd0, 1'b1, 1'b1);
        check(out_flags == 4'b1000, "R6", {60'd0, out_flags}, 64'b1000);
        op_and_check("R7", 1'b0, 64'hFFFF_FFFF, 64'd1, 3'b010, 3'd0, 1'b0, 1'b1);
        check(out_flags == 4'b0110, "R7", {60'd0, out_flags}, 64'b0110);
        op_and_check("R7", 1'b0, 64'h8000_0000, 64'd1, 3'b010, 3'd0, 1'b1, 1'b1);
        check(out_flags == 4'b0011, "R7", {60'd0, out_flags}, 64'b0011);
    endtask

    task automatic t_illegal;
        logic [63:0] r;
        logic [3:0]  f;
        logic        v, il;
        op_and_check("R8", 1'b1, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 3'b011, 3'd0, 1'b0, 1'b1);
        for (int s = 5; s < 8; s++) begin
            run_op(1'b1, 64'd0, 64'd0, 3'b011, 3'(s), 1'b0, 1'b1, r, f, v, il);
            check(il && v, "R8", {62'd0, il, v}, 64'd3);
            check(r == 64'd0, "R8", r, 64'd0);
            check(f == 4'b1001, "R8", {60'd0, f}, 64'b1001);
        end
    endtask

    task automatic t_hold;
        op_and_check("R9", 1'b1, 64'd3, 64'd3, 3'b011, 3'd0, 1'b1, 1'b0);
        check(out_result == 64'd0 && out_flags == 4'b1001, "R9", {60'd0, out_flags}, 64'b1001);
        @(negedge clk);
        check(out_valid == 1'b0, "R10", {63'd0, out_valid}, 64'd0);
        check(out_flags == 4'b1001, "R9", {60'd0, out_flags}, 64'b1001);
    endtask

    initial begin
        #(8 * 200000);
        bad++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; wide_sel = 1'b1; src_a = '0; src_b = '0;
        ext_opt = '0; shamt = '0; do_sub = 1'b0; set_flags = 1'b0;
        exp_flags = 4'd0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_fill_modes();
        t_shift();
        t_narrow_codes();
        t_wide_dword();
        t_flags();
        t_illegal();
        t_hold();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule